// File: doc/BRIEF.md
# Pixel Unpacker with Alpha Modifier

This block turns one incoming pixel word into a normalized 32-bit pixel with alpha in bits 31:24, red in 23:16, green in 15:8 and blue in 7:0. The word is read in one of several colour modes chosen by a 4-bit mode code. An optional byte-pair swap and an optional channel-order reversal change the input layout before decoding. After decoding, the alpha channel is changed according to a 2-bit alpha mode and an 8-bit alpha value.

The palette modes do not decode colour themselves. They put the index on a palette port and take the 32-bit palette entry that comes back in the same cycle. The alpha-only modes take their alpha from the word and their red, green and blue from a 24-bit fixed-colour input. Words enter through a valid/ready handshake and leave, one cycle later, through a registered valid/ready output stage.

Top module: `pixel_unpack`

## Requirements
- R1: After synchronous reset, out_valid, out_err and out_pixel are all zero and in_ready is high.
- R2: in_ready equals (not out_valid) or out_ready. An accepted word appears on the output one clock later. While out_valid is high and out_ready is low, out_pixel and out_err hold their values.
- R3: Mode 0 reads a 32-bit word laid out A,R,G,B from bit 31 down. Mode 1 reads R,G,B from bits 23:0 and ignores bits 31:24.
- R4: Mode 2 reads red from bits 15:11, green from 10:5 and blue from 4:0. Each field is widened to 8 bits by appending its own top bits.
- R5: Mode 4 drives bits 7:0 of the word onto pal_idx. Mode 5 drives bits 3:0 with the upper index nibble zero. In both modes the output pixel is the pal_data entry.
- R6: Mode 6 takes alpha from bits 7:0 and mode 7 takes it from bits 3:0, with the nibble repeated in both halves. In both modes red, green and blue come from cfg_fix_rgb.
- R7: With cfg_rgb_swap set, the channel order of modes 0, 1 and 2 is reversed. Mode 0 is then read as B,G,R,A from bit 31 down, mode 1 as B,G,R, and mode 2 as blue in 15:11 and red in 4:0.
- R8: With cfg_byte_swap set, modes 0 and 2 exchange byte 0 with byte 1 and byte 2 with byte 3 before decoding. Every other mode ignores the swap.
- R9: In alpha mode 0 (no change), the alpha of the decoded pixel is kept, and modes 1 and 2 give alpha 255.
- R10: Alpha mode 1 replaces alpha with cfg_alpha_val.
- R11: Alpha mode 2 outputs floor(alpha × cfg_alpha_val / 256).
- R12: Alpha mode 3 outputs 255 minus alpha.
- R13: Mode codes 3 and 8 to 15 are illegal. They produce out_err high and out_pixel zero, whatever the alpha mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can accept a word |
| in_word | input | 32 | Packed input pixel |
| cfg_mode | input | 4 | Colour mode code |
| cfg_rgb_swap | input | 1 | Reverse channel order |
| cfg_byte_swap | input | 1 | Swap bytes within each 16-bit half |
| cfg_alpha_mode | input | 2 | 0 keep, 1 fixed, 2 scale, 3 invert |
| cfg_alpha_val | input | 8 | Fixed alpha or scale factor |
| cfg_fix_rgb | input | 24 | Colour used by the alpha-only modes |
| pal_idx | output | 8 | Palette index |
| pal_data | input | 32 | Palette entry for pal_idx, same cycle |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the pixel |
| out_pixel | output | 32 | Normalized pixel, A in 31:24 |
| out_err | output | 1 | Pixel came from an illegal mode code |

## Verification
The bench targets these corners:
- Byte swap requested in modes that must ignore it. A design that swaps anyway scrambles RGB888 output.
- The 4-bit palette index. A design that leaks the upper nibble fetches the wrong entry.
- Scale products just under 256, which must truncate to zero. A design that rounds gives 1.
- Illegal codes combined with the fixed-alpha mode. A design that zeroes only the colour leaks the fixed alpha into the output.
- A stalled output. A design that ignores out_ready overwrites the held pixel.
- The RGB565 widening and the reversed layouts. Random words cover these against a bench model.

// File: rtl/pixel_unpack_pkg.sv
package pixel_unpack_pkg;
  localparam int CH_W   = 8;
  localparam int WORD_W = 4 * CH_W;
  localparam int RGB_W  = 3 * CH_W;

  localparam logic [3:0] PM_ARGB32 = 4'd0;
  localparam logic [3:0] PM_RGB24  = 4'd1;
  localparam logic [3:0] PM_RGB16  = 4'd2;
  localparam logic [3:0] PM_PAL8   = 4'd4;
  localparam logic [3:0] PM_PAL4   = 4'd5;
  localparam logic [3:0] PM_ALPHA8 = 4'd6;
  localparam logic [3:0] PM_ALPHA4 = 4'd7;

  typedef enum logic [1:0] {
    AM_KEEP   = 2'd0,
    AM_FIXED  = 2'd1,
    AM_SCALE  = 2'd2,
    AM_INVERT = 2'd3
  } alpha_mode_t;

  typedef struct packed {
    logic [CH_W-1:0] a;
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } argb_t;
endpackage

// File: rtl/pixel_unpack_swap.sv
module pixel_unpack_swap
  import pixel_unpack_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [3:0]        mode_i,
  input  logic              byte_swap_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int HALF_W = 2 * CH_W;
  localparam int N_HALF = WORD_W / HALF_W;

  logic honour;
  assign honour = byte_swap_i && ((mode_i == PM_ARGB32) || (mode_i == PM_RGB16));

  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    assign word_o[h*HALF_W +: HALF_W] = honour ?
      {word_i[h*HALF_W +: CH_W], word_i[h*HALF_W+CH_W +: CH_W]} :
      word_i[h*HALF_W +: HALF_W];
  end
endmodule

// File: rtl/pixel_unpack_decode.sv
module pixel_unpack_decode
  import pixel_unpack_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [3:0]        mode_i,
  input  logic              rgb_swap_i,
  input  logic [RGB_W-1:0]  fix_rgb_i,
  input  logic [WORD_W-1:0] pal_data_i,
  output logic [CH_W-1:0]   pal_idx_o,
  output argb_t             px_o,
  output logic              err_o
);
  logic [4:0] f_hi, f_lo;
  logic [5:0] f_mid;
  logic [CH_W-1:0] w5_hi, w5_lo, w6_mid;

  assign f_hi   = word_i[15:11];
  assign f_mid  = word_i[10:5];
  assign f_lo   = word_i[4:0];
  assign w5_hi  = {f_hi, f_hi[4:2]};
  assign w5_lo  = {f_lo, f_lo[4:2]};
  assign w6_mid = {f_mid, f_mid[5:4]};

  assign pal_idx_o = (mode_i == PM_PAL4) ? {4'h0, word_i[3:0]} : word_i[CH_W-1:0];

  always_comb begin
    px_o  = '0;
    err_o = 1'b0;
    case (mode_i)
      PM_ARGB32: begin
        if (rgb_swap_i)
          px_o = '{a: word_i[7:0], r: word_i[15:8], g: word_i[23:16], b: word_i[31:24]};
        else
          px_o = '{a: word_i[31:24], r: word_i[23:16], g: word_i[15:8], b: word_i[7:0]};
      end
      PM_RGB24: begin
        if (rgb_swap_i)
          px_o = '{a: 8'hFF, r: word_i[7:0], g: word_i[15:8], b: word_i[23:16]};
        else
          px_o = '{a: 8'hFF, r: word_i[23:16], g: word_i[15:8], b: word_i[7:0]};
      end
      PM_RGB16: begin
        if (rgb_swap_i)
          px_o = '{a: 8'hFF, r: w5_lo, g: w6_mid, b: w5_hi};
        else
          px_o = '{a: 8'hFF, r: w5_hi, g: w6_mid, b: w5_lo};
      end
      PM_PAL8, PM_PAL4: px_o = pal_data_i;
      PM_ALPHA8: px_o = {word_i[7:0], fix_rgb_i};
      PM_ALPHA4: px_o = {word_i[3:0], word_i[3:0], fix_rgb_i};
      default: err_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/pixel_unpack_alpha.sv
module pixel_unpack_alpha
  import pixel_unpack_pkg::*;
(
  input  argb_t           px_i,
  input  alpha_mode_t     mode_i,
  input  logic [CH_W-1:0] val_i,
  output argb_t           px_o
);
  logic [2*CH_W-1:0] prod;
  assign prod = px_i.a * val_i;

  always_comb begin
    px_o = px_i;
    case (mode_i)
      AM_KEEP:   px_o.a = px_i.a;
      AM_FIXED:  px_o.a = val_i;
      AM_SCALE:  px_o.a = prod[2*CH_W-1:CH_W];
      AM_INVERT: px_o.a = ~px_i.a;
      default:   px_o.a = px_i.a;
    endcase
  end
endmodule

// File: rtl/pixel_unpack.sv
module pixel_unpack
  import pixel_unpack_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic [3:0]        cfg_mode,
  input  logic              cfg_rgb_swap,
  input  logic              cfg_byte_swap,
  input  logic [1:0]        cfg_alpha_mode,
  input  logic [CH_W-1:0]   cfg_alpha_val,
  input  logic [RGB_W-1:0]  cfg_fix_rgb,
  output logic [CH_W-1:0]   pal_idx,
  input  logic [WORD_W-1:0] pal_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_pixel,
  output logic              out_err
);
  logic [WORD_W-1:0] word_sw;
  argb_t             px_dec, px_alp;
  logic              dec_err;
  logic [WORD_W-1:0] px_next;

  pixel_unpack_swap u_swap (
    .word_i(in_word), .mode_i(cfg_mode), .byte_swap_i(cfg_byte_swap), .word_o(word_sw)
  );

  pixel_unpack_decode u_dec (
    .word_i(word_sw), .mode_i(cfg_mode), .rgb_swap_i(cfg_rgb_swap),
    .fix_rgb_i(cfg_fix_rgb), .pal_data_i(pal_data), .pal_idx_o(pal_idx),
    .px_o(px_dec), .err_o(dec_err)
  );

  pixel_unpack_alpha u_alpha (
    .px_i(px_dec), .mode_i(alpha_mode_t'(cfg_alpha_mode)), .val_i(cfg_alpha_val), .px_o(px_alp)
  );

  assign px_next  = dec_err ? '0 : px_alp;
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pixel <= '0;
      out_err   <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_pixel <= px_next;
        out_err   <= dec_err;
      end
    end
  end

  a_r2_hold_when_stalled: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pixel) && $stable(out_err)));

  a_r2_accept_gives_valid: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  a_r9_opaque_rgb24: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && cfg_mode == PM_RGB24 && cfg_alpha_mode == 2'd0)
      |=> (out_pixel[31:24] == 8'hFF));

  a_r6_alpha_only_colour: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && (cfg_mode == PM_ALPHA8 || cfg_mode == PM_ALPHA4))
      |=> (out_pixel[RGB_W-1:0] == $past(cfg_fix_rgb)));

  a_r13_err_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_err) |-> (out_pixel == '0));
endmodule

// File: tb/pixel_unpack_tb.sv
module pixel_unpack_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ready;
  logic [31:0] in_word;
  logic [3:0]  cfg_mode;
  logic        cfg_rgb_swap, cfg_byte_swap;
  logic [1:0]  cfg_alpha_mode;
  logic [7:0]  cfg_alpha_val;
  logic [23:0] cfg_fix_rgb;
  logic [7:0]  pal_idx;
  logic [31:0] pal_data;
  logic        out_valid, out_ready;
  logic [31:0] out_pixel;
  logic        out_err;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  function automatic logic [31:0] pal_f(input logic [7:0] i);
    return {~i, i, i ^ 8'h5A, i + 8'd3};
  endfunction

  assign pal_data = pal_f(pal_idx);

  pixel_unpack u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .cfg_mode(cfg_mode), .cfg_rgb_swap(cfg_rgb_swap), .cfg_byte_swap(cfg_byte_swap),
    .cfg_alpha_mode(cfg_alpha_mode), .cfg_alpha_val(cfg_alpha_val), .cfg_fix_rgb(cfg_fix_rgb),
    .pal_idx(pal_idx), .pal_data(pal_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_pixel(out_pixel), .out_err(out_err)
  );

  function automatic logic [32:0] model(input logic [31:0] w0, input logic [3:0] m,
      input logic rs, input logic bs, input logic [1:0] am, input logic [7:0] av,
      input logic [23:0] fx);
    logic [31:0] w;
    logic [7:0] a, r, g, b;
    logic [15:0] p;
    w = w0;
    if (bs && (m == 4'd0 || m == 4'd2)) w = {w[23:16], w[31:24], w[7:0], w[15:8]};
    case (m)
      4'd0: if (rs) {b, g, r, a} = w; else {a, r, g, b} = w;
      4'd1: begin a = 8'hFF; if (rs) {b, g, r} = w[23:0]; else {r, g, b} = w[23:0]; end
      4'd2: begin
        a = 8'hFF;
        r = rs ? {w[4:0], w[4:2]} : {w[15:11], w[15:13]};
        b = rs ? {w[15:11], w[15:13]} : {w[4:0], w[4:2]};
        g = {w[10:5], w[10:9]};
      end
      4'd4: {a, r, g, b} = pal_f(w[7:0]);
      4'd5: {a, r, g, b} = pal_f({4'h0, w[3:0]});
      4'd6: begin a = w[7:0]; {r, g, b} = fx; end
      4'd7: begin a = {w[3:0], w[3:0]}; {r, g, b} = fx; end
      default: return {1'b1, 32'h0};
    endcase
    p = a * av;
    case (am)
      2'd1: a = av;
      2'd2: a = p[15:8];
      2'd3: a = 8'd255 - a;
      default: ;
    endcase
    return {1'b0, a, r, g, b};
  endfunction

  task automatic chk(input string req, input logic [32:0] act, input logic [32:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("[TB] FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic one(input string req, input logic [31:0] w, input logic [3:0] m,
      input logic rs, input logic bs, input logic [1:0] am, input logic [7:0] av,
      input logic [23:0] fx);
    logic [32:0] e;
    @(negedge clk);
    in_word = w; cfg_mode = m; cfg_rgb_swap = rs; cfg_byte_swap = bs;
    cfg_alpha_mode = am; cfg_alpha_val = av; cfg_fix_rgb = fx; in_valid = 1'b1;
    e = model(w, m, rs, bs, am, av, fx);
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, {32'h0, out_valid}, 33'd1);
    chk(req, {out_err, out_pixel}, e);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("[TB] FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [3:0] mlist [12];
    void'($urandom(32'd1234));
    mlist = '{4'd0, 4'd1, 4'd2, 4'd4, 4'd5, 4'd6, 4'd7, 4'd0, 4'd2, 4'd3, 4'd9, 4'd15};
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1; in_word = '0; cfg_mode = '0;
    cfg_rgb_swap = 0; cfg_byte_swap = 0; cfg_alpha_mode = 0; cfg_alpha_val = 0; cfg_fix_rgb = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", {out_err, out_pixel}, 33'h0);
    chk("R1", {31'h0, out_valid, in_ready}, 33'd1);

    one("R3", 32'h11223344, 4'd0, 0, 0, 2'd0, 8'h00, 24'h0);
    one("R3", 32'hAB123456, 4'd1, 0, 0, 2'd0, 8'h00, 24'h0);
    chk("R9", {1'b0, out_pixel[31:24], 24'h0}, {1'b0, 8'hFF, 24'h0});
    one("R4", 32'h00008410, 4'd2, 0, 0, 2'd0, 8'h00, 24'h0);
    chk("R4", {1'b0, out_pixel}, {1'b0, 32'hFF848284});
    one("R9", 32'h0000F81F, 4'd2, 0, 0, 2'd0, 8'h00, 24'h0);

    // R5 palette index and entry
    @(negedge clk);
    in_word = 32'hFFFFFFA7; cfg_mode = 4'd5; cfg_alpha_mode = 2'd0; #1;
    chk("R5", {25'h0, pal_idx}, {25'h0, 8'h07});
    cfg_mode = 4'd4; #1;
    chk("R5", {25'h0, pal_idx}, {25'h0, 8'hA7});
    one("R5", 32'hFFFFFFA7, 4'd5, 0, 0, 2'd0, 8'h00, 24'h0);
    one("R5", 32'h000000C3, 4'd4, 0, 1, 2'd0, 8'h00, 24'h0);

    one("R6", 32'h0000000C, 4'd7, 0, 0, 2'd0, 8'h00, 24'h123456);
    chk("R6", {1'b0, out_pixel}, {1'b0, 32'hCC123456});
    one("R6", 32'h0000005E, 4'd6, 1, 1, 2'd0, 8'h00, 24'hABCDEF);

    one("R7", 32'h11223344, 4'd0, 1, 0, 2'd0, 8'h00, 24'h0);
    chk("R7", {1'b0, out_pixel}, {1'b0, 32'h44332211});
    one("R7", 32'h00ABCDEF, 4'd1, 1, 0, 2'd0, 8'h00, 24'h0);
    one("R7", 32'h0000F800, 4'd2, 1, 0, 2'd0, 8'h00, 24'h0);

    one("R8", 32'h11223344, 4'd0, 0, 1, 2'd0, 8'h00, 24'h0);
    chk("R8", {1'b0, out_pixel}, {1'b0, 32'h22114433});
    one("R8", 32'h00112233, 4'd1, 0, 1, 2'd0, 8'h00, 24'h0);
    chk("R8", {1'b0, out_pixel}, {1'b0, 32'hFF112233});
    one("R8", 32'h00001F84, 4'd2, 0, 1, 2'd0, 8'h00, 24'h0);

    one("R10", 32'h11223344, 4'd0, 0, 0, 2'd1, 8'h40, 24'h0);
    chk("R10", {1'b0, out_pixel}, {1'b0, 32'h40223344});
    one("R11", 32'hFF223344, 4'd0, 0, 0, 2'd2, 8'h80, 24'h0);
    chk("R11", {25'h0, out_pixel[31:24]}, {25'h0, 8'h7F});
    one("R11", 32'h03223344, 4'd0, 0, 0, 2'd2, 8'h55, 24'h0);
    chk("R11", {25'h0, out_pixel[31:24]}, 33'h0);
    one("R12", 32'h30223344, 4'd0, 0, 0, 2'd3, 8'h00, 24'h0);
    chk("R12", {25'h0, out_pixel[31:24]}, {25'h0, 8'hCF});

    one("R13", 32'h11223344, 4'd3, 0, 0, 2'd1, 8'h77, 24'h0);
    chk("R13", {out_err, out_pixel}, {1'b1, 32'h0});
    one("R13", 32'hDEADBEEF, 4'd12, 1, 1, 2'd3, 8'h77, 24'h0);
    one("R13", 32'h00000001, 4'd0, 0, 0, 2'd0, 8'h00, 24'h0);
    chk("R13", {32'h0, out_err}, 33'h0);

    // R2 stall: output held, in_ready low, next word accepted after release
    @(negedge clk);
    out_ready = 1'b0;
    in_word = 32'hA1B2C3D4; cfg_mode = 4'd0; cfg_rgb_swap = 0; cfg_byte_swap = 0;
    cfg_alpha_mode = 2'd0; in_valid = 1'b1;
    @(negedge clk);
    chk("R2", {31'h0, out_valid, in_ready}, 33'd2);
    in_word = 32'h55667788;
    @(negedge clk);
    chk("R2", {out_err, out_pixel}, {1'b0, 32'hA1B2C3D4});
    chk("R2", {32'h0, in_ready}, 33'h0);
    out_ready = 1'b1;
    #1;
    chk("R2", {32'h0, in_ready}, 33'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2", {out_err, out_pixel}, {1'b0, 32'h55667788});
    @(negedge clk);
    chk("R2", {32'h0, out_valid}, 33'h0);

    for (int i = 0; i < 400; i++) begin
      one("RAND", $urandom, mlist[$urandom % 12], 1'($urandom), 1'($urandom),
          2'($urandom), 8'($urandom), 24'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule